// File: doc/BRIEF.md
# Dual Output Clock Divider

The block turns one fast input clock into two slower clocks, each with a 50% duty cycle. A single 2-bit ratio code sets the divide ratios of both outputs together. Output 0 divides by 1 or 2. Output 1 divides by 2, 3, 4 or 6. The divide-by-3 case still gives equal high and low times: the output is built from one state updated on the rising edge and one updated on the falling edge, so each half lasts 1.5 input periods.

The ratio code is asynchronous to the input clock. It passes through a synchronizer and takes effect only at a rising edge where both phase counters are at their last count. This keeps both outputs free of runt pulses and keeps their rising edges aligned.

The output enable is sampled only at the rising edge that starts a pulse. A pulse that has started always runs to its full width. Reset puts both outputs at the end of a joint period, so the first rising edge after reset starts a new, aligned period on both outputs.

Top module: `dclk_top`

## Requirements
- R1: Code 2'b00 (bit 1 is the MSB) makes output 0 a divide-by-2 clock and output 1 a divide-by-4 clock.
- R2: Code 2'b01 makes output 0 follow the input clock (divide-by-1) and output 1 a divide-by-2 clock.
- R3: Code 2'b10 makes output 0 a divide-by-2 clock and output 1 a divide-by-6 clock.
- R4: Code 2'b11 makes output 0 a divide-by-1 clock and output 1 a divide-by-3 clock.
- R5: Every ratio gives a 50% duty cycle. For divide-by-D, the output is high for D input half-periods starting at a rising edge. For divide-by-3 this is the whole first input period plus the first half of the second.
- R6: While reset is high, both outputs are low and the active code is 2'b00. The first rising edge after reset is the start of a joint period, and both outputs begin a high phase there if the enable is high.
- R7: A new code is sampled on rising edges through a two-stage synchronizer. It is applied only at a rising edge where both phase counters are at their last count. The code applied at such an edge is the input value sampled two rising edges earlier, and both phase counters restart from zero there.
- R8: The enable is sampled at the rising edge that starts each output pulse. If it is low there, the pulse is suppressed and the output stays low for that pulse. Once a pulse has started, it is never shortened by the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_i | input | 1 | Active-high asynchronous reset |
| oe_i | input | 1 | Output enable, sampled at each pulse start |
| nsel_i | input | 2 | Ratio code selecting the pair of divide ratios |
| q0_o | output | 1 | Divided clock 0 (divide-by-1 or 2) |
| q1_o | output | 1 | Divided clock 1 (divide-by-2, 3, 4 or 6) |

## Verification
A code switch and a change of the enable can land on the same rising edge, because the joint-wrap edge is also a pulse-start edge for both outputs. In that case the new ratio and the sampled enable must combine correctly on the first pulse of the new period. The bench provokes this with a pseudo-random stream that toggles the enable and the code on many edges, some of which fall on joint wraps. A behavioural model tracks the synchronizer delay, the wrap points and the enable sampled at each pulse start, and compares both outputs in both halves of every input period.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int CODE_W = 2;
    localparam int CNT_W  = 3;
    localparam logic [CODE_W-1:0] DEF_CODE = 2'b00;

    // ratio of output 0: odd codes give divide-by-1
    function automatic logic [CNT_W-1:0] ratio_out0(input logic [CODE_W-1:0] code);
        return code[0] ? CNT_W'(1) : CNT_W'(2);
    endfunction

    // ratio of output 1
    function automatic logic [CNT_W-1:0] ratio_out1(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            2'b00:   r = CNT_W'(4);
            2'b01:   r = CNT_W'(2);
            2'b10:   r = CNT_W'(6);
            default: r = CNT_W'(3);
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [CODE_W-1:0] act;   // active ratio code
        logic [CNT_W-1:0]  c0;    // phase of output 0
        logic [CNT_W-1:0]  c1;    // phase of output 1
        logic              h0;    // rising-edge pulse state, output 0
        logic              h1;    // rising-edge pulse state, output 1
        logic              p0;    // toggle used for divide-by-1
        logic              div1;  // output 0 runs at divide-by-1
        logic              odd1;  // output 1 runs at an odd ratio
    } dclk_st_t;

endpackage

// File: rtl/dclk_sync.sv
module dclk_sync #(
    parameter int W = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) stg_q <= {STAGES{RST_VAL}};
                else       stg_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i) stg_q <= {STAGES{RST_VAL}};
                else       stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dclk_negstage.sv
module dclk_negstage #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] n_q;

    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) n_q <= '0;
        else       n_q <= d_i;
    end

    assign q_o = n_q;

endmodule

// File: rtl/dclk_top.sv
module dclk_top
    import dclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              oe_i,
    input  logic [CODE_W-1:0] nsel_i,
    output logic              q0_o,
    output logic              q1_o
);

    localparam logic [CNT_W-1:0] RST_C0 = ratio_out0(DEF_CODE) - CNT_W'(1);
    localparam logic [CNT_W-1:0] RST_C1 = ratio_out1(DEF_CODE) - CNT_W'(1);

    dclk_st_t          st_d, st_q;
    logic [CODE_W-1:0] code_sync;
    logic [1:0]        neg_q;

    logic [CNT_W-1:0]  r0_cur, r1_cur, r0_new, r1_new, half0, half1;
    logic              wrap;

    dclk_sync #(
        .W      (CODE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(DEF_CODE)
    ) i_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (nsel_i),
        .q_o   (code_sync)
    );

    always_comb begin
        st_d   = st_q;
        r0_cur = ratio_out0(st_q.act);
        r1_cur = ratio_out1(st_q.act);
        wrap   = (st_q.c0 == r0_cur - CNT_W'(1)) && (st_q.c1 == r1_cur - CNT_W'(1));

        if (wrap) begin
            st_d.act = code_sync;
            st_d.c0  = '0;
            st_d.c1  = '0;
        end else begin
            st_d.c0 = (st_q.c0 == r0_cur - CNT_W'(1)) ? '0 : st_q.c0 + CNT_W'(1);
            st_d.c1 = (st_q.c1 == r1_cur - CNT_W'(1)) ? '0 : st_q.c1 + CNT_W'(1);
        end

        r0_new = ratio_out0(st_d.act);
        r1_new = ratio_out1(st_d.act);
        half0  = r0_new >> 1;
        half1  = r1_new >> 1;

        // pulse starts at phase zero gated by enable; then held for the half ratio
        if (st_d.c0 == '0)         st_d.h0 = oe_i;
        else if (st_d.c0 < half0)  st_d.h0 = st_q.h0;
        else                       st_d.h0 = 1'b0;

        if (st_d.c1 == '0)         st_d.h1 = oe_i;
        else if (st_d.c1 < half1)  st_d.h1 = st_q.h1;
        else                       st_d.h1 = 1'b0;

        st_d.div1 = (r0_new == CNT_W'(1));
        st_d.odd1 = r1_new[0];
        st_d.p0   = st_q.p0 ^ (st_d.div1 & oe_i);
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            st_q.act  <= DEF_CODE;
            st_q.c0   <= RST_C0;
            st_q.c1   <= RST_C1;
            st_q.h0   <= 1'b0;
            st_q.h1   <= 1'b0;
            st_q.p0   <= 1'b0;
            st_q.div1 <= (ratio_out0(DEF_CODE) == CNT_W'(1));
            st_q.odd1 <= ratio_out1(DEF_CODE) [0];
        end else begin
            st_q <= st_d;
        end
    end

    // falling-edge half of the divide-by-1 toggle pair and the odd-ratio extension
    dclk_negstage #(.W(2)) i_neg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({st_q.p0, st_q.h1 & st_q.odd1}),
        .q_o   (neg_q)
    );

    assign q0_o = st_q.div1 ? (st_q.p0 ^ neg_q[1]) : st_q.h0;
    assign q1_o = st_q.h1 | neg_q[0];

    // plain views of internal state for the bound checker
    logic [CODE_W-1:0] act_w;
    logic [CNT_W-1:0]  c0_w, c1_w;
    logic              h1_w, odd1_w;
    assign act_w  = st_q.act;
    assign c0_w   = st_q.c0;
    assign c1_w   = st_q.c1;
    assign h1_w   = st_q.h1;
    assign odd1_w = st_q.odd1;

endmodule

// File: rtl/dclk_chk.sv
module dclk_chk
    import dclk_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              oe_i,
    input logic [CODE_W-1:0] act_i,
    input logic [CNT_W-1:0]  c0_i,
    input logic [CNT_W-1:0]  c1_i,
    input logic              h1_i,
    input logic              odd1_i
);

    // R7
    code_at_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_i != $past(act_i)) |-> (c0_i == '0 && c1_i == '0));

    // R5
    phase_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (c1_i < ratio_out1(act_i)) && (c0_i < ratio_out0(act_i)));

    // R8
    pulse_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(h1_i) |-> $past(oe_i));

    // R6
    rise_at_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(h1_i) |-> (c1_i == '0));

    // R4
    odd_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (odd1_i && h1_i) |=> !h1_i);

endmodule

bind dclk_top dclk_chk i_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .oe_i   (oe_i),
    .act_i  (act_w),
    .c0_i   (c0_w),
    .c1_i   (c1_w),
    .h1_i   (h1_w),
    .odd1_i (odd1_w)
);

// File: tb/test_dclk_top.sv
module test_dclk_top;

    logic       clk = 1'b0;
    logic       rst_i;
    logic       oe_i;
    logic [1:0] nsel_i;
    logic       q0_o, q1_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    string tag = "R6";

    always #5 clk = ~clk;

    dclk_top i_dclk_top (
        .clk_i  (clk),
        .rst_i  (rst_i),
        .oe_i   (oe_i),
        .nsel_i (nsel_i),
        .q0_o   (q0_o),
        .q1_o   (q1_o)
    );

    // behavioural model state
    int m_code, m_c0, m_c1;
    bit m_e0, m_e1;
    int m_pipe[$];

    function automatic int rat0(int code);
        return (code % 2 == 1) ? 1 : 2;
    endfunction

    function automatic int rat1(int code);
        case (code)
            0: return 4;
            1: return 2;
            2: return 6;
            default: return 3;
        endcase
    endfunction

    task automatic model_edge();
        if (rst_i) begin
            m_code = 0;
            m_c0 = rat0(0) - 1;
            m_c1 = rat1(0) - 1;
            m_e0 = 0;
            m_e1 = 0;
            m_pipe = '{0, 0};
        end else begin
            if (m_c0 == rat0(m_code) - 1 && m_c1 == rat1(m_code) - 1) begin
                m_code = m_pipe[0];
                m_c0 = 0;
                m_c1 = 0;
            end else begin
                m_c0 = (m_c0 + 1) % rat0(m_code);
                m_c1 = (m_c1 + 1) % rat1(m_code);
            end
            if (m_c0 == 0) m_e0 = oe_i;
            if (m_c1 == 0) m_e1 = oe_i;
            m_pipe.push_back(int'(nsel_i));
            void'(m_pipe.pop_front());
        end
    endtask

    function automatic bit exp0(int half);
        if (rat0(m_code) == 1) return (half == 0) && m_e0;
        return (m_c0 < rat0(m_code) / 2) && m_e0;
    endfunction

    function automatic bit exp1(int half);
        int d = rat1(m_code);
        if (d == 3) begin
            if (m_c1 == 0) return m_e1;
            if (m_c1 == 1) return (half == 0) && m_e1;
            return 0;
        end
        return (m_c1 < d / 2) && m_e1;
    endfunction

    task automatic compare(int half);
        bit e0 = exp0(half);
        bit e1 = exp1(half);
        n_chk++;
        if (q0_o !== e0) begin
            n_fail++;
            $display("FAIL %s q0 code=%0d half=%0d actual=%0b expected=%0b", tag, m_code, half, q0_o, e0);
        end
        n_chk++;
        if (q1_o !== e1) begin
            n_fail++;
            $display("FAIL %s q1 code=%0d half=%0d actual=%0b expected=%0b", tag, m_code, half, q1_o, e1);
        end
    endtask

    task automatic step_cycle();
        @(posedge clk);
        model_edge();
        #2;
        compare(0);
        @(negedge clk);
        #2;
        compare(1);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lfsr;
        rst_i = 1'b1;
        oe_i = 1'b0;
        nsel_i = 2'b00;
        // R6: reset holds both outputs low
        tag = "R6";
        run(3);
        rst_i = 1'b0;
        oe_i = 1'b1;
        run(4);
        // R1
        tag = "R1";
        run(24);
        // R2
        tag = "R2";
        nsel_i = 2'b01;
        run(24);
        // R3
        tag = "R3";
        nsel_i = 2'b10;
        run(30);
        // R4
        tag = "R4";
        nsel_i = 2'b11;
        run(30);
        // R5: long odd and even runs for duty cycle
        tag = "R5";
        run(60);
        nsel_i = 2'b10;
        run(60);
        // R7: a one-cycle code glitch and back-to-back code changes
        tag = "R7";
        nsel_i = 2'b01;
        run(1);
        nsel_i = 2'b10;
        run(20);
        nsel_i = 2'b11;
        run(2);
        nsel_i = 2'b00;
        run(20);
        // R8: enable low suppresses pulses; mid-pulse changes never cut them
        tag = "R8";
        oe_i = 1'b0;
        run(16);
        for (int i = 0; i < 48; i++) begin
            oe_i = (i % 5 < 2);
            run(1);
        end
        nsel_i = 2'b11;
        for (int i = 0; i < 48; i++) begin
            oe_i = (i % 3 != 0);
            run(1);
        end
        // R6: reset in mid-run restores alignment
        tag = "R6";
        rst_i = 1'b1;
        run(2);
        rst_i = 1'b0;
        run(12);
        // R7: enable and code changes falling on joint wraps together
        tag = "R7";
        lfsr = 32'h1ACE;
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            if (lfsr[3:0] == 4'h0) nsel_i = lfsr[5:4];
            if (lfsr[8:6] == 3'h0) oe_i = ~oe_i;
            run(1);
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule